// File: doc/BRIEF.md
# Windowed Register File with Sliding Name Window

This block is a register file that software and the issue logic see as 32 registers, named by 5-bit numbers. The storage behind those names is a larger physical array. A window pointer picks which slice of that array the 32 names reach. Each window step adds 16 to the physical index, so two neighbouring windows share 16 entries. The upper half of the names in one window is the same storage as the lower half of the names in the next window. This lets a caller pass values to a callee without copying anything.

The file has one write port and two read ports, all addressed by architectural names. Reads are combinational from the translated index. A read that hits the physical entry being written in the same cycle returns the new data. Writes land on the rising clock edge.

Two request inputs slide the window up or down by one step. A move takes one cycle and moves no data. A request that would leave the valid range of windows is refused: the pointer does not change, and an overflow or underflow flag rises for the following cycle. Parameters set the number of windows and the data width. The physical depth is 16·(windows−1)+32, which is 128 entries for the default of 7 windows.

Top module: `win_regfile`

## Requirements
- R1: Asynchronous active-low reset sets the window pointer to 0, clears every physical entry to zero, and drives both flags low.
- R2: A read of name n while the pointer is w returns physical entry n + 16·w, for n in 0..31 and w in 0..NUM_WIN−1.
- R3: When the write enable is high, the data is stored on the rising edge into entry (write name) + 16·w, where w is the pointer value before that edge. This holds even when a window move is requested in the same cycle.
- R4: An advance request alone (advance 1, retreat 0) while w < NUM_WIN−1 sets the pointer to w+1 at the next edge. Contents are not moved, so name n+16 in window w reads the same entry as name n in window w+1.
- R5: A retreat request alone while w > 0 sets the pointer to w−1 at the next edge, again without moving contents.
- R6: An advance request alone while w = NUM_WIN−1 leaves the pointer unchanged. The overflow output is high during the cycle after that edge, and it stays high only while such requests keep arriving.
- R7: A retreat request alone while w = 0 leaves the pointer unchanged. The underflow output is high during the cycle after that edge, under the same one-cycle-per-request rule.
- R8: Advance and retreat requested together act as no request: the pointer holds and neither flag rises.
- R9: When a read port addresses the same physical entry that is being written in the same cycle, that port returns the write data combinationally. This applies to both ports.
- R10: With the write enable low, the write name and write data have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_adv | input | 1 | Request to slide the window up by one step |
| win_ret | input | 1 | Request to slide the window down by one step |
| wr_en | input | 1 | Write enable |
| wr_name | input | 5 | Architectural name written |
| wr_data | input | DATA_W | Write data |
| rd0_name | input | 5 | Architectural name for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data |
| rd1_name | input | 5 | Architectural name for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data |
| win_ovf | output | 1 | Refused advance at the top window, one cycle per request |
| win_unf | output | 1 | Refused retreat at window 0, one cycle per request |

## Verification
The bench walks the pointer through every window right after reset and reads all 32 names in each. A design that cleared only part of the array, or translated with the wrong step, would return stale or misplaced values there. It writes through one window and reads the same storage through a neighbouring one, which catches any design that copies on a move or offsets by the wrong amount. It pushes the pointer past both ends and requests both moves at once. This exposes a pointer that wraps, a flag that sticks high or never rises, or a simultaneous request that counts as a move. Directed and random same-cycle write-read collisions catch a missing bypass, and a write issued together with a move catches a design that writes into the new window.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

   // architectural name space
   localparam int unsigned NAME_W   = 5;
   localparam int unsigned NAMES    = 1 << NAME_W;
   // a window slides by half the name space
   localparam int unsigned STEP_LOG = NAME_W - 1;
   localparam int unsigned WIN_STEP = 1 << STEP_LOG;

   typedef logic [NAME_W-1:0] name_t;

   // encoded as {advance, retreat}
   typedef enum logic [1:0] {
      MV_HOLD = 2'b00,
      MV_RET  = 2'b01,
      MV_ADV  = 2'b10,
      MV_BOTH = 2'b11
   } move_e;

   function automatic int unsigned phys_depth(input int unsigned nwin);
      return WIN_STEP * (nwin - 1) + NAMES;
   endfunction

endpackage

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl
   import wrf_pkg::*;
#(
   parameter int unsigned NUM_WIN = 7,
   parameter int unsigned PTR_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             ret_i,
   output logic [PTR_W-1:0] win_o,
   output logic             ovf_o,
   output logic             unf_o
);

   localparam logic [PTR_W-1:0] TOP_WIN = PTR_W'(NUM_WIN - 1);

   move_e            mv;
   logic [PTR_W-1:0] win_q, win_d;
   logic             ovf_q, ovf_d, unf_q, unf_d;

   assign mv = move_e'({adv_i, ret_i});

   always_comb begin
      win_d = win_q;
      ovf_d = 1'b0;
      unf_d = 1'b0;
      unique case (mv)
         MV_ADV: begin
            if (win_q == TOP_WIN) ovf_d = 1'b1;
            else                  win_d = win_q + PTR_W'(1);
         end
         MV_RET: begin
            if (win_q == '0) unf_d = 1'b1;
            else             win_d = win_q - PTR_W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         win_q <= win_d;
         ovf_q <= ovf_d;
         unf_q <= unf_d;
      end
   end

   assign win_o = win_q;
   assign ovf_o = ovf_q;
   assign unf_o = unf_q;

   // R4
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !ret_i && win_q != TOP_WIN) |=> (win_q == $past(win_q) + PTR_W'(1)));

   // R5
   ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !adv_i && win_q != '0) |=> (win_q == $past(win_q) - PTR_W'(1)));

   // R6
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (win_q == TOP_WIN && $past(adv_i && !ret_i)));

   // R7
   unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |-> (win_q == '0 && $past(ret_i && !adv_i)));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i == ret_i) |=> ($stable(win_q) && !ovf_o && !unf_o));

endmodule

// File: rtl/wrf_xlate.sv
module wrf_xlate
   import wrf_pkg::*;
#(
   parameter int unsigned PTR_W = 3,
   parameter int unsigned IDX_W = 7
) (
   input  name_t            name_i,
   input  logic [PTR_W-1:0] win_i,
   output logic [IDX_W-1:0] idx_o
);

   // window offset is a shift: the step is a power of two
   assign idx_o = IDX_W'(name_i) + (IDX_W'(win_i) << STEP_LOG);

endmodule

// File: rtl/wrf_array.sv
module wrf_array #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned NRD    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [IDX_W-1:0]          widx_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [NRD-1:0][IDX_W-1:0] ridx_i,
   output logic [NRD-1:0][DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[widx_i] <= wdata_i;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic hit;
      assign hit        = we_i && (widx_i == ridx_i[p]);
      assign rdata_o[p] = hit ? wdata_i : mem_q[ridx_i[p]];
   end

   // R3
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem_q[$past(widx_i)] == $past(wdata_i)));

endmodule

// File: rtl/win_regfile.sv
module win_regfile
   import wrf_pkg::*;
#(
   parameter int unsigned NUM_WIN = 7,
   parameter int unsigned DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_adv,
   input  logic              win_ret,
   input  logic              wr_en,
   input  logic [4:0]        wr_name,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [4:0]        rd0_name,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [4:0]        rd1_name,
   output logic [DATA_W-1:0] rd1_data,
   output logic              win_ovf,
   output logic              win_unf
);

   localparam int unsigned DEPTH = phys_depth(NUM_WIN);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned PTR_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int unsigned NRD   = 2;
   localparam int unsigned LANES = NRD + 1;   // lane 0 writes, the rest read

   initial begin
      assert (NUM_WIN >= 2) else $error("win_regfile: NUM_WIN must be at least 2");
      assert (DATA_W >= 1)  else $error("win_regfile: DATA_W must be at least 1");
      assert (NAME_W == 5)  else $error("win_regfile: name width must be 5");
   end

   logic [PTR_W-1:0]             win;
   logic [LANES-1:0][NAME_W-1:0] lane_name;
   logic [LANES-1:0][IDX_W-1:0]  lane_idx;
   logic [NRD-1:0][IDX_W-1:0]    ridx;
   logic [NRD-1:0][DATA_W-1:0]   rdata;

   wrf_win_ctrl #(
      .NUM_WIN (NUM_WIN),
      .PTR_W   (PTR_W)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (win_adv),
      .ret_i (win_ret),
      .win_o (win),
      .ovf_o (win_ovf),
      .unf_o (win_unf)
   );

   assign lane_name[0] = wr_name;
   assign lane_name[1] = rd0_name;
   assign lane_name[2] = rd1_name;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wrf_xlate #(
         .PTR_W (PTR_W),
         .IDX_W (IDX_W)
      ) u_xlate (
         .name_i (lane_name[l]),
         .win_i  (win),
         .idx_o  (lane_idx[l])
      );
      if (l > 0) begin : g_rd
         assign ridx[l-1] = lane_idx[l];
      end
   end

   wrf_array #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W),
      .NRD    (NRD)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_en),
      .widx_i  (lane_idx[0]),
      .wdata_i (wr_data),
      .ridx_i  (ridx),
      .rdata_o (rdata)
   );

   assign rd0_data = rdata[0];
   assign rd1_data = rdata[1];

   // R6
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_ovf && win_unf));

endmodule

// File: tb/win_regfile_tb.sv
module win_regfile_tb;

   localparam int NW      = 7;
   localparam int DW      = 32;
   localparam int DEPTH   = 16 * (NW - 1) + 32;
   localparam int CLK_PER = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          win_adv = 1'b0, win_ret = 1'b0, wr_en = 1'b0;
   logic [4:0]    wr_name = '0, rd0_name = '0, rd1_name = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd0_data, rd1_data;
   logic          win_ovf, win_unf;

   win_regfile #(.NUM_WIN(NW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .win_adv(win_adv), .win_ret(win_ret),
      .wr_en(wr_en), .wr_name(wr_name), .wr_data(wr_data),
      .rd0_name(rd0_name), .rd0_data(rd0_data),
      .rd1_name(rd1_name), .rd1_data(rd1_data),
      .win_ovf(win_ovf), .win_unf(win_unf)
   );

   always #(CLK_PER/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model
   logic [DW-1:0] ref_mem [DEPTH];
   int            ref_win = 0;
   bit            exp_ovf = 1'b0, exp_unf = 1'b0;

   task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp,
                      input string tag, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic int phys(input logic [4:0] n, input int w);
      return int'(n) + 16 * w;
   endfunction

   function automatic logic [DW-1:0] exp_read(input logic [4:0] n, input bit we,
                                              input logic [4:0] wn, input logic [DW-1:0] wd);
      if (we && wn == n) return wd;
      return ref_mem[phys(n, ref_win)];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      ref_win = 0;
      exp_ovf = 1'b0;
      exp_unf = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; win_adv = 0; win_ret = 0; wr_en = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle: drive, check combinational reads and flags, then model the edge
   task automatic step(input bit adv, input bit ret, input bit we,
                       input logic [4:0] wn, input logic [DW-1:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb, input string tag);
      string ta, tb;
      @(negedge clk);
      win_adv = adv; win_ret = ret; wr_en = we;
      wr_name = wn; wr_data = wd; rd0_name = ra; rd1_name = rb;
      #1;
      ta = (tag != "") ? tag : ((we && wn == ra) ? "R9" : "R2");
      tb = (tag != "") ? tag : ((we && wn == rb) ? "R9" : "R2");
      chk(rd0_data, exp_read(ra, we, wn, wd), ta, "rd0");
      chk(rd1_data, exp_read(rb, we, wn, wd), tb, "rd1");
      chk(DW'(win_ovf), DW'(exp_ovf), "R6", "overflow flag");
      chk(DW'(win_unf), DW'(exp_unf), "R7", "underflow flag");
      // model of the coming edge: write uses the pre-move window
      if (we) ref_mem[phys(wn, ref_win)] = wd;
      exp_ovf = 1'b0;
      exp_unf = 1'b0;
      if (adv && !ret) begin
         if (ref_win == NW - 1) exp_ovf = 1'b1;
         else                   ref_win++;
      end else if (ret && !adv) begin
         if (ref_win == 0) exp_unf = 1'b1;
         else              ref_win--;
      end
   endtask

   task automatic sweep(input string tag);
      for (int n = 0; n < 32; n++)
         step(0, 0, 0, '0, '0, 5'(n), 5'(31 - n), tag);
   endtask

   initial begin
      logic [DW-1:0] va, vb, vc;
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();

      // R1: every entry zero after reset, seen through all windows
      sweep("R1");
      for (int w = 1; w < NW; w++) begin
         step(1, 0, 0, '0, '0, 5'd0, 5'd31, "R4");
         sweep("R1");
      end
      // R6: refused advance at the top, flag for one cycle per request
      step(1, 0, 0, '0, '0, 5'd0, 5'd1, "R6");
      step(1, 0, 0, '0, '0, 5'd2, 5'd3, "R6");
      step(0, 0, 0, '0, '0, 5'd4, 5'd5, "R6");
      step(0, 0, 0, '0, '0, 5'd4, 5'd5, "R6");
      // R5/R7: walk down and past the bottom
      for (int w = 0; w < NW; w++) step(0, 1, 0, '0, '0, 5'd6, 5'd7, "R5");
      step(0, 0, 0, '0, '0, 5'd6, 5'd7, "R7");
      step(0, 0, 0, '0, '0, 5'd6, 5'd7, "R7");

      // R4: name 20 in window 0 aliases name 4 in window 1
      va = 32'hA5A5_0020;
      step(0, 0, 1, 5'd20, va, 5'd20, 5'd0, "R9");
      step(1, 0, 0, '0, '0, 5'd20, 5'd0, "R2");
      step(0, 0, 0, '0, '0, 5'd4, 5'd20, "R4");
      step(0, 1, 0, '0, '0, 5'd4, 5'd20, "R4");
      step(0, 0, 0, '0, '0, 5'd20, 5'd4, "R5");

      // R3: write together with an advance lands in the old window
      vb = 32'h0BAD_F00D;
      step(1, 0, 1, 5'd3, vb, 5'd0, 5'd1, "R3");
      step(0, 1, 0, '0, '0, 5'd3, 5'd19, "R3");
      step(0, 0, 0, '0, '0, 5'd3, 5'd19, "R3");

      // R8: both requests at window 0 do nothing
      step(1, 1, 0, '0, '0, 5'd20, 5'd3, "R8");
      step(0, 0, 0, '0, '0, 5'd20, 5'd3, "R8");
      step(1, 1, 0, '0, '0, 5'd20, 5'd3, "R8");
      step(0, 0, 0, '0, '0, 5'd20, 5'd3, "R8");

      // R9: same-cycle bypass on both ports
      vc = 32'h1234_5677;
      step(0, 0, 1, 5'd7, vc, 5'd7, 5'd7, "R9");
      // R10: disabled write leaves the entry alone
      step(0, 0, 0, 5'd7, 32'hDEAD_BEEF, 5'd8, 5'd9, "R10");
      step(0, 0, 0, 5'd7, 32'hFFFF_FFFF, 5'd7, 5'd7, "R10");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom_range(0, 15));
         bit a = (r < 2) || (r == 15);
         bit t = (r >= 2 && r < 4) || (r == 15);
         bit we = $urandom_range(0, 1) == 1;
         logic [4:0] wn = 5'($urandom);
         logic [4:0] ra = ($urandom_range(0, 3) == 0) ? wn : 5'($urandom);
         logic [4:0] rb = 5'($urandom);
         step(a, t, we, wn, DW'($urandom), ra, rb, "");
      end

      // R1: reset again with live contents and a non-zero window
      do_reset();
      sweep("R1");
      step(1, 0, 0, '0, '0, 5'd0, 5'd0, "R1");
      sweep("R1");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule